// File: doc/BRIEF.md
# Address-As-Data Memory Tester

This block is a destructive self-test engine for a word-wide memory split into two equal banks. It reaches the memory through a simple synchronous word port: one access per cycle, with read data returned one cycle after the read request. Each test step has two phases. In the fill phase it writes every word of a range with data derived from that word's own address. In the read phase it reads the range back and compares each word with the value it should hold.

A run is started by a pulse on `start_i` and always follows the same order of steps. It first tests the whole memory with true data and then with inverted data. It then tests the lower bank alone and finally the upper bank alone. For a status display, the block shows the current step, whether it is filling or comparing, and a coarse progress digit from 1 to 8. The run stops at the first mismatch. It then reports an error code that names the step, and it holds the failing word address and the data that was read. At the end, `done_o` pulses once and `pass_o` gives the verdict.

Top module: `addr_data_memtest`

## Requirements
- R1: In the true-data steps (step codes 0, 2 and 3), each word is written with its byte address as data: the word address shifted left by two, zero-extended to the data width. The word is later compared against that same value.
- R2: In step code 1, the written and the expected data are the bitwise inverse of the R1 value.
- R3: Steps run in the order 0 (whole memory, true data), 1 (whole memory, inverted data), 2 (lower half only) and 3 (upper half only). `step_o` carries the step code. In each step, addresses are written in ascending order from the bottom of its range.
- R4: `phase_o` is 0 while a step fills, when every memory access is a write. It is 1 while a step reads back, when every memory access is a read.
- R5: During every memory access, `progress_o` equals the top three bits of the word address plus one, so it runs from 1 to 8 across the whole memory.
- R6: The first mismatch ends the run, and no further memory access is made. `err_code_o` then reads 11, 12, 13 or 14 for step code 0, 1, 2 or 3.
- R7: On a mismatch, `fail_addr_o` holds the word address that failed and `fail_data_o` holds the data read from it.
- R8: `done_o` is high for exactly one cycle at the end of each run. `pass_o` is 1 only if no mismatch occurred. After a passing run, `err_code_o`, `fail_addr_o` and `fail_data_o` read 0.
- R9: After reset, `busy_o`, `done_o`, `pass_o`, `err_code_o` and `mem_en_o` are all 0.
- R10: A `start_i` pulse while a run is in progress is ignored. The run completes with 3 x 2^AW writes and 3 x 2^AW reads, and with a single `done_o` pulse.
- R11: A mismatch on the last word of a step is reported with that step's code. It is not lost in the change to the next step, and this includes the last word of the final step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, used only when idle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Last run had no mismatch |
| step_o | output | 2 | Current step code |
| phase_o | output | 1 | 0 fill, 1 read and compare |
| progress_o | output | 4 | Progress digit 1 to 8 |
| err_code_o | output | 4 | 0, or 11 to 14 on a mismatch |
| fail_addr_o | output | AW | Word address of the first mismatch |
| fail_data_o | output | DW | Data read at the first mismatch |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, one cycle after the read request |

## Verification
Because of the one-cycle read latency, the compare for the last word of a step falls in the same cycle as the move to the next step. In the final step it also falls in the same cycle as the end-of-run decision. The bench provokes this with a memory model that corrupts the top word of the memory. In one run the fault is present from the start, so it must be reported with code 11. In another run the fault is armed only once step 3 begins, so it must be reported with code 14. In both cases the exact address and the corrupted data must be reported, and no access may follow the done pulse. Other runs place faults that show only under inverted data, or only after the whole-memory steps, so that each error code appears once. A clean run with a start pulse injected mid-run confirms that the access counts are not disturbed.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {
    STEP_FULL     = 2'd0,
    STEP_FULL_INV = 2'd1,
    STEP_LOW      = 2'd2,
    STEP_HIGH     = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_READ,
    ST_TAIL
  } state_e;

  function automatic logic [3:0] err_code(step_e s);
    return 4'd11 + {2'b00, s};
  endfunction
endpackage

// File: rtl/mt_range.sv
module mt_range
  import mt_pkg::*;
#(
  parameter int AW = 10
) (
  input  step_e         step_i,
  output logic [AW-1:0] lo_o,
  output logic [AW-1:0] hi_o
);
  // bank 1 is the upper half, bank 0 the lower half
  assign lo_o = (step_i == STEP_HIGH) ? {1'b1, {(AW-1){1'b0}}} : '0;
  assign hi_o = (step_i == STEP_LOW)  ? {1'b0, {(AW-1){1'b1}}} : '1;
endmodule

// File: rtl/mt_pattern.sv
module mt_pattern #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic          inv_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] base;

  always_comb begin
    base = '0;
    base[AW+1:0] = {addr_i, 2'b00};
  end

  assign data_o = inv_i ? ~base : base;
endmodule

// File: rtl/mt_check.sv
module mt_check #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [AW-1:0] addr_i,
  input  logic          inv_i,
  input  logic [DW-1:0] rdata_i,
  output logic          mism_o,
  output logic [AW-1:0] pend_addr_o
);
  logic          pend_vld_q;
  logic          pend_inv_q;
  logic [AW-1:0] pend_addr_q;
  logic [DW-1:0] exp_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q  <= 1'b0;
      pend_inv_q  <= 1'b0;
      pend_addr_q <= '0;
    end else begin
      pend_vld_q <= issue_i;
      if (issue_i) begin
        pend_inv_q  <= inv_i;
        pend_addr_q <= addr_i;
      end
    end
  end

  mt_pattern #(.AW(AW), .DW(DW)) u_exp (
    .addr_i(pend_addr_q),
    .inv_i (pend_inv_q),
    .data_o(exp_data)
  );

  assign mism_o      = pend_vld_q && (rdata_i != exp_data);
  assign pend_addr_o = pend_addr_q;
endmodule

// File: rtl/addr_data_memtest.sv
module addr_data_memtest
  import mt_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [1:0]    step_o,
  output logic          phase_o,
  output logic [3:0]    progress_o,
  output logic [3:0]    err_code_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [DW-1:0] fail_data_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int PW = 3;  // progress digit covers eighths of the space

  state_e        state_q;
  step_e         step_q, rng_step;
  logic [AW-1:0] cnt_q, rng_lo, rng_hi, pend_addr, fail_addr_q;
  logic [DW-1:0] fail_data_q;
  logic [3:0]    err_q;
  logic          done_q, pass_q, mism, at_hi, inv, issue;

  assign inv      = (step_q == STEP_FULL_INV);
  assign issue    = (state_q == ST_READ);
  // in the tail cycle the range unit already looks at the next step
  assign rng_step = (state_q == ST_TAIL) ? step_e'(step_q + 2'd1) : step_q;
  assign at_hi    = (cnt_q == rng_hi);

  mt_range #(.AW(AW)) u_range (
    .step_i(rng_step),
    .lo_o  (rng_lo),
    .hi_o  (rng_hi)
  );

  mt_pattern #(.AW(AW), .DW(DW)) u_wpat (
    .addr_i(cnt_q),
    .inv_i (inv),
    .data_o(mem_wdata_o)
  );

  mt_check #(.AW(AW), .DW(DW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue),
    .addr_i     (cnt_q),
    .inv_i      (inv),
    .rdata_i    (mem_rdata_i),
    .mism_o     (mism),
    .pend_addr_o(pend_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      step_q      <= STEP_FULL;
      cnt_q       <= '0;
      done_q      <= 1'b0;
      pass_q      <= 1'b0;
      err_q       <= '0;
      fail_addr_q <= '0;
      fail_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if ((state_q == ST_READ || state_q == ST_TAIL) && mism) begin
        state_q     <= ST_IDLE;
        done_q      <= 1'b1;
        pass_q      <= 1'b0;
        err_q       <= err_code(step_q);
        fail_addr_q <= pend_addr;
        fail_data_q <= mem_rdata_i;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i) begin
            state_q     <= ST_FILL;
            step_q      <= STEP_FULL;
            cnt_q       <= '0;
            pass_q      <= 1'b0;
            err_q       <= '0;
            fail_addr_q <= '0;
            fail_data_q <= '0;
          end
          ST_FILL: begin
            if (at_hi) begin
              state_q <= ST_READ;
              cnt_q   <= rng_lo;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_READ: begin
            if (at_hi) state_q <= ST_TAIL;
            else       cnt_q   <= cnt_q + 1'b1;
          end
          ST_TAIL: begin
            if (step_q == STEP_HIGH) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              pass_q  <= 1'b1;
            end else begin
              step_q  <= rng_step;
              cnt_q   <= rng_lo;
              state_q <= ST_FILL;
            end
          end
        endcase
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign step_o      = step_q;
  assign phase_o     = (state_q == ST_READ) || (state_q == ST_TAIL);
  assign progress_o  = {1'b0, cnt_q[AW-1 -: PW]} + 4'd1;
  assign err_code_o  = err_q;
  assign fail_addr_o = fail_addr_q;
  assign fail_data_o = fail_data_q;
  assign mem_en_o    = (state_q == ST_FILL) || (state_q == ST_READ);
  assign mem_we_o    = (state_q == ST_FILL);
  assign mem_addr_o  = cnt_q;
endmodule

// File: rtl/mt_sva.sv
module mt_sva #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          pass_o,
  input logic [1:0]    step_o,
  input logic          phase_o,
  input logic [3:0]    err_code_o,
  input logic          mem_en_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o
);
  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    logic [DW-1:0] p;
    p = '0;
    p[AW+1:0] = {a, 2'b00};
    return p;
  endfunction

  assert_fill_writes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && !phase_o |-> mem_we_o);
  assert_read_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && phase_o |-> !mem_we_o);
  assert_true_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && mem_we_o && step_o != 2'd1 |-> mem_wdata_o == pat(mem_addr_o));
  assert_inv_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && mem_we_o && step_o == 2'd1 |-> mem_wdata_o == ~pat(mem_addr_o));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_pass_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && pass_o |-> err_code_o == 4'd0);
  assert_fail_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !pass_o |-> err_code_o == 4'd11 + {2'b00, step_o});
  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_en_o);
  assert_step_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> step_o == $past(step_o) || step_o == $past(step_o) + 2'd1);
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> busy_o || done_o);
endmodule

bind addr_data_memtest mt_sva #(.AW(AW), .DW(DW)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .step_o     (step_o),
  .phase_o    (phase_o),
  .err_code_o (err_code_o),
  .mem_en_o   (mem_en_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o)
);

// File: tb/tb_addr_data_memtest.sv
module tb_addr_data_memtest;
  localparam int AW     = 10;
  localparam int DW     = 32;
  localparam int DEPTH  = 1 << AW;
  localparam int PERIOD = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          busy_o, done_o, pass_o, phase_o;
  logic [1:0]    step_o;
  logic [3:0]    progress_o, err_code_o;
  logic [AW-1:0] fail_addr_o, mem_addr_o;
  logic [DW-1:0] fail_data_o, mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          mem_en_o, mem_we_o;

  always #(PERIOD/2) clk_i = ~clk_i;

  addr_data_memtest #(.AW(AW), .DW(DW)) dut (.*);

  typedef struct {
    bit          pass;
    int          code;
    int          addr;
    logic [31:0] data;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  // fault model: kind 0 stuck-at-0, 1 stuck-at-1, 2 flip; -1 none
  int f_kind = -1, f_addr = 0, f_arm = -1;
  bit armed = 0;
  logic [DW-1:0] f_mask = '0;
  logic [DW-1:0] mem [DEPTH];

  int seq_err, pat_err, ph_err, prog_err, wr_cnt, rd_cnt, post_acc, done_cnt;
  int last_step, next_addr;
  bit done_seen;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] pat(int a, bit inv);
    logic [DW-1:0] p;
    p = DW'(a) << 2;
    return inv ? ~p : p;
  endfunction

  function automatic logic [DW-1:0] corrupt(int a, logic [DW-1:0] w);
    if (f_kind < 0 || a != f_addr || (f_arm >= 0 && !armed)) return w;
    case (f_kind)
      0:       return w & ~f_mask;
      1:       return w | f_mask;
      default: return w ^ f_mask;
    endcase
  endfunction

  // synchronous memory, read latency one cycle
  always @(posedge clk_i) begin
    if (mem_en_o) begin
      if (mem_we_o) mem[mem_addr_o] <= corrupt(int'(mem_addr_o), mem_wdata_o);
      else          mem_rdata_i <= mem[mem_addr_o];
    end
  end

  // monitor: access checks and scoreboard pop on done
  always @(negedge clk_i) begin
    exp_t e;
    if (rst_ni) begin
      if (f_arm >= 0 && busy_o && int'(step_o) == f_arm) armed = 1;
      if (mem_en_o) begin
        int a, s;
        a = int'(mem_addr_o);
        s = int'(step_o);
        if (done_seen) post_acc++;
        if (phase_o != !mem_we_o) ph_err++;
        if (int'(progress_o) != (a >> (AW-3)) + 1) prog_err++;
        if (mem_we_o) begin
          wr_cnt++;
          if (mem_wdata_o != pat(a, s == 1)) pat_err++;
          if (s != last_step) begin
            if (s != last_step + 1 || a != ((s == 3) ? DEPTH/2 : 0)) seq_err++;
            last_step = s;
          end else if (a != next_addr) seq_err++;
          if (a > ((s == 2) ? DEPTH/2 - 1 : DEPTH - 1)) seq_err++;
          next_addr = a + 1;
        end else rd_cnt++;
      end
      if (done_o) begin
        done_cnt++;
        done_seen = 1;
        if (exp_q.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(pass_o == e.pass, "R8", "pass flag", pass_o, e.pass);
          chk(int'(err_code_o) == e.code, "R6", "error code", err_code_o, e.code);
          chk(int'(fail_addr_o) == e.addr, "R7", "fail address", fail_addr_o, e.addr);
          chk(fail_data_o == e.data, "R7", "fail data", fail_data_o, e.data);
        end
      end
    end
  end

  // driver: set fault, push expectation, start, wait, judge run
  task automatic run_case(int kind, int addr, logic [DW-1:0] mask, int arm,
                          bit epass, int ecode, int eaddr, logic [31:0] edata,
                          bit restart, string tag);
    exp_t e;
    int t;
    f_kind = kind; f_addr = addr; f_mask = mask; f_arm = arm; armed = 0;
    seq_err = 0; pat_err = 0; ph_err = 0; prog_err = 0; wr_cnt = 0; rd_cnt = 0;
    post_acc = 0; done_cnt = 0; last_step = -1; next_addr = 0; done_seen = 0;
    e.pass = epass; e.code = ecode; e.addr = eaddr; e.data = edata;
    exp_q.push_back(e);
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    if (restart) begin
      repeat (100) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
    end
    t = 0;
    while (!done_seen && t < 20000) begin @(negedge clk_i); t++; end
    repeat (30) @(negedge clk_i);
    chk(done_seen, "R8", {tag, " run finished"}, done_seen, 1);
    chk(done_cnt == 1, "R8", {tag, " done pulses"}, done_cnt, 1);
    chk(post_acc == 0, "R6", {tag, " accesses after end"}, post_acc, 0);
    chk(seq_err == 0, "R3", {tag, " step/address order"}, seq_err, 0);
    chk(pat_err == 0, "R1", {tag, " write data (R2 for step 1)"}, pat_err, 0);
    chk(ph_err == 0, "R4", {tag, " phase vs access"}, ph_err, 0);
    chk(prog_err == 0, "R5", {tag, " progress digit"}, prog_err, 0);
    if (epass) begin
      chk(wr_cnt == 3*DEPTH, "R10", {tag, " write count"}, wr_cnt, 3*DEPTH);
      chk(rd_cnt == 3*DEPTH, "R10", {tag, " read count"}, rd_cnt, 3*DEPTH);
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(!busy_o && !done_o && !pass_o, "R9", "flags after reset", {busy_o, done_o, pass_o}, 0);
    chk(err_code_o == 0 && !mem_en_o, "R9", "code/access after reset", {err_code_o, mem_en_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // clean run with a start pulse mid-run (R10, R8)
    run_case(-1, 0, '0, -1, 1, 0, 0, 32'h0, 1, "clean");
    // stuck-at-1 bit 31 at word 7: true pass fails, code 11
    run_case(1, 7, 32'h8000_0000, -1, 0, 11, 7, 32'h8000_001C, 0, "R6 step0");
    // stuck-at-0 bit 0 at word 5: only inverted data shows it (R2), code 12
    run_case(0, 5, 32'h1, -1, 0, 12, 5, 32'hFFFF_FFEA, 0, "R2 step1");
    // flip bit 8 at word 3 armed in step 2: code 13
    run_case(2, 3, 32'h100, 2, 0, 13, 3, 32'h0000_010C, 0, "R6 step2");
    // R11: top word fails in step 0, compare lands in the step change
    run_case(1, DEPTH-1, 32'h8000_0000, -1, 0, 11, DEPTH-1, 32'h8000_0FFC, 0, "R11 step0 last");
    // R11: top word fails only in final step, code 14
    run_case(2, DEPTH-1, 32'h1, 3, 0, 14, DEPTH-1, 32'h0000_0FFD, 0, "R11 step3 last");
    // clean run after failures clears error state (R8)
    run_case(-1, 0, '0, -1, 1, 0, 0, 32'h0, 0, "R8 rerun");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule